// File: doc/BRIEF.md
# ADC conversion request arbiter

This block decides which conversion a shared converter core performs next. Two kinds of work compete for the core. A single conversion samples one selected channel. A scan sequence walks through every channel whose bit is set in an 8-bit channel mask. Requests come from software command pulses or from a hardware trigger line. For each kind, an enable and a selector pick that line out of a bundle of one-cycle trigger pulses. The arbiter issues one conversion at a time to the core with a start pulse and a channel number. It waits for the core's done pulse and stores the returned sample in a result register for that kind, together with a valid flag.

A scan is served ahead of a single conversion, but it never breaks into a single conversion that is already running. An optional tailgate mode holds a requested single conversion back until the next scan sequence has completed. The single conversion then starts on the very next cycle, so a scan started periodically by a timer is never pushed back by single traffic. Stop commands cancel pending work and abandon an in-flight conversion of that kind. An abandoned conversion also wipes that kind's result register.

Top module: `adc_conv_arbiter`

## Requirements
- R1: After reset both active flags, both valid flags, both result registers, the scan result channel tag and `core_start` are all zero.
- R2: The core receives at most one conversion at a time. `core_start` is never high while a conversion is outstanding, except in the cycle in which `core_done` returns. A scan request never interrupts a running single conversion. A request sampled at one clock edge produces `core_start` high in the cycle after the following edge.
- R3: When a single request and a scan request are pending together, every conversion of the scan sequence is issued before the single conversion.
- R4: A scan issues one conversion for each set bit of `scan_mask`, from the lowest to the highest bit index, with `core_chan` equal to the bit index. The mask is captured when the request is accepted. A request with an all-zero mask is dropped and leaves `scan_active` low.
- R5: While `tailgate_en` is 1, an accepted single request is not issued until a scan sequence has completed. Its `core_start` then appears exactly one cycle after the cycle in which `core_done` returned the last conversion of that scan.
- R6: A stop command cancels the pending and in-flight work of its kind, and that kind's active flag is low after the next edge. When a start and a stop for the same kind arrive in the same cycle, the start is taken and the stop is ignored.
- R7: A stop that lands while a conversion of its kind is in flight clears that kind's result register to zero and its valid flag to 0. The late `core_done` of the abandoned conversion is discarded. A stop with no conversion of its kind in flight leaves the results untouched.
- R8: `single_active` is high while a single request is pending (including while it is held by tailgating) or its conversion is in flight. `scan_active` is high from the accepted scan request until the last conversion of the sequence completes.
- R9: A request for a kind is raised by its software start pulse, or by `hw_trig[sel]` when that kind's hardware enable is 1 and `sel` is its select field. Pulses on other trigger lines have no effect. Software start still works while the hardware enable is set.
- R10: A request for a kind that is already pending or in flight is merged into the existing one and produces no extra conversion.
- R11: On a non-abandoned `core_done`, the returned sample is stored in the result register of the kind that issued the conversion and its valid flag is set. For a scan, `scan_result_chan` holds the channel of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| single_start_cmd | input | 1 | Software start pulse for single conversion |
| single_stop_cmd | input | 1 | Software stop pulse for single conversion |
| scan_start_cmd | input | 1 | Software start pulse for scan sequence |
| scan_stop_cmd | input | 1 | Software stop pulse for scan sequence |
| tailgate_en | input | 1 | Hold single requests until the next scan completes |
| single_hw_en | input | 1 | Enable hardware trigger for single conversion |
| single_hw_sel | input | TSEL_W (3) | Trigger line used for single conversion |
| scan_hw_en | input | 1 | Enable hardware trigger for scan |
| scan_hw_sel | input | TSEL_W (3) | Trigger line used for scan |
| hw_trig | input | NTRIG (8) | One-cycle hardware trigger pulses |
| single_chan | input | CH_W (3) | Channel for single conversion |
| scan_mask | input | NCHAN (8) | Channels included in a scan |
| core_start | output | 1 | One-cycle start pulse to the converter core |
| core_chan | output | CH_W (3) | Channel of the issued conversion |
| core_done | input | 1 | Completion pulse from the core |
| core_result | input | RES_W (12) | Sample returned with `core_done` |
| single_active | output | 1 | Single conversion pending or in flight |
| scan_active | output | 1 | Scan sequence pending or in flight |
| single_result | output | RES_W (12) | Last single sample |
| single_valid | output | 1 | `single_result` holds a sample |
| scan_result | output | RES_W (12) | Last scan sample |
| scan_result_chan | output | CH_W (3) | Channel of `scan_result` |
| scan_valid | output | 1 | `scan_result` holds a sample |

## Verification
Two situations are hard to reach from the ports. One is the release of a tailgated single request in the cycle right after the last scan completion. The other is a stop that lands while the core is still working, followed later by a stale done pulse that must be thrown away. The bench drives a converter model with a fixed latency that records the cycle of every done pulse, so the gap to the next start can be measured exactly. Stop commands are placed by counting cycles from the start pulse, so they fall inside the core's latency window. A scoreboard queue holds the channel order each scenario expects and compares it at every start pulse. Any start that was not expected is therefore caught as well, including one caused by merging or a dropped request.

// File: rtl/adcarb_pkg.sv
package adcarb_pkg;
  // Which request class owns a conversion
  typedef enum logic {
    CLS_SINGLE = 1'b0,
    CLS_SCAN   = 1'b1
  } conv_class_e;
endpackage

// File: rtl/adcarb_trig_sel.sv
module adcarb_trig_sel #(
  parameter int NTRIG = 8,
  localparam int TSEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              hw_en,
  input  logic [TSEL_W-1:0] hw_sel,
  input  logic [NTRIG-1:0]  hw_trig,
  output logic              req,
  output logic              stop_eff
);
  logic hw_hit;

  assign hw_hit   = hw_en & hw_trig[hw_sel];
  assign req      = sw_start | hw_hit;
  // a start in the same cycle overrides the stop
  assign stop_eff = sw_stop & ~req;
endmodule

// File: rtl/adcarb_scan_seq.sv
module adcarb_scan_seq #(
  parameter int NCHAN = 8,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCHAN-1:0] mask,
  input  logic             advance,
  input  logic             finish,
  input  logic             kill,
  output logic             run,
  output logic             has_next,
  output logic [CH_W-1:0]  next_chan,
  output logic             left_empty
);
  logic [NCHAN-1:0] left_q;

  function automatic logic [CH_W-1:0] first_set(input logic [NCHAN-1:0] m);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = NCHAN - 1; i >= 0; i--) begin
      if (m[i]) idx = CH_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [NCHAN-1:0] drop_first(input logic [NCHAN-1:0] m);
    return m & (m - NCHAN'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      left_q <= '0;
    end else if (kill) begin
      run    <= 1'b0;
      left_q <= '0;
    end else if (load) begin
      run    <= |mask;
      left_q <= mask;
    end else begin
      if (advance) left_q <= drop_first(left_q);
      if (finish)  run    <= 1'b0;
    end
  end

  assign has_next   = |left_q;
  assign left_empty = ~|left_q;
  assign next_chan  = first_set(left_q);

  // R4: an empty mask never starts a sequence
  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mask == '0) |=> !run);

  // R6: a stop leaves no sequence running
  assert_scan_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!run && left_empty));
endmodule

// File: rtl/adcarb_core_ctl.sv
module adcarb_core_ctl
  import adcarb_pkg::*;
#(
  parameter int NCHAN = 8,
  parameter int RES_W = 12,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             single_req,
  input  logic             single_stop,
  input  logic [CH_W-1:0]  single_chan,
  input  logic             tailgate_en,
  input  logic             scan_stop,
  input  logic             scan_run,
  input  logic             scan_has_next,
  input  logic [CH_W-1:0]  scan_next_chan,
  input  logic             scan_left_empty,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_result,
  output logic             scan_issue,
  output logic             scan_end,
  output logic             core_start,
  output logic [CH_W-1:0]  core_chan,
  output logic             single_active,
  output logic [RES_W-1:0] single_result,
  output logic             single_valid,
  output logic [RES_W-1:0] scan_result,
  output logic [CH_W-1:0]  scan_result_chan,
  output logic             scan_valid
);
  logic        busy_q, abort_q, single_pend_q, single_gate_q;
  conv_class_e cls_q;

  // named events for the assertions
  logic core_free, done_live, single_inflight, scan_inflight;
  logic single_accept, single_can, scan_can, single_issue;
  logic kill_single, kill_scan;

  assign core_free       = !busy_q || core_done;
  assign single_inflight = busy_q && !abort_q && (cls_q == CLS_SINGLE);
  assign scan_inflight   = busy_q && !abort_q && (cls_q == CLS_SCAN);
  assign done_live       = core_done && busy_q && !abort_q;
  assign kill_single     = single_stop && single_inflight;
  assign kill_scan       = scan_stop && scan_inflight;

  assign scan_end      = done_live && (cls_q == CLS_SCAN) && scan_run && scan_left_empty && !scan_stop;
  assign single_accept = single_req && !single_pend_q && !single_inflight;
  assign scan_can      = scan_run && scan_has_next && !scan_stop;
  assign single_can    = single_pend_q && (!single_gate_q || scan_end) && !single_stop;
  assign scan_issue    = core_free && scan_can;
  assign single_issue  = core_free && single_can && !scan_can;

  // issue and in-flight tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      abort_q    <= 1'b0;
      cls_q      <= CLS_SINGLE;
      core_start <= 1'b0;
      core_chan  <= '0;
    end else begin
      core_start <= scan_issue || single_issue;
      if (scan_issue || single_issue) begin
        busy_q    <= 1'b1;
        abort_q   <= 1'b0;
        cls_q     <= scan_issue ? CLS_SCAN : CLS_SINGLE;
        core_chan <= scan_issue ? scan_next_chan : single_chan;
      end else if (core_done) begin
        busy_q  <= 1'b0;
        abort_q <= 1'b0;
      end else if (kill_single || kill_scan) begin
        abort_q <= 1'b1;
      end
    end
  end

  // single request bookkeeping, including tailgate hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_pend_q <= 1'b0;
      single_gate_q <= 1'b0;
    end else if (single_stop) begin
      single_pend_q <= 1'b0;
      single_gate_q <= 1'b0;
    end else if (single_accept) begin
      single_pend_q <= 1'b1;
      single_gate_q <= tailgate_en;
    end else begin
      if (single_issue) single_pend_q <= 1'b0;
      if (single_issue || scan_end) single_gate_q <= 1'b0;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_result    <= '0;
      single_valid     <= 1'b0;
      scan_result      <= '0;
      scan_result_chan <= '0;
      scan_valid       <= 1'b0;
    end else begin
      if (kill_single) begin
        single_result <= '0;
        single_valid  <= 1'b0;
      end else if (done_live && cls_q == CLS_SINGLE) begin
        single_result <= core_result;
        single_valid  <= 1'b1;
      end
      if (kill_scan) begin
        scan_result      <= '0;
        scan_result_chan <= '0;
        scan_valid       <= 1'b0;
      end else if (done_live && cls_q == CLS_SCAN) begin
        scan_result      <= core_result;
        scan_result_chan <= core_chan;
        scan_valid       <= 1'b1;
      end
    end
  end

  assign single_active = single_pend_q || single_inflight;

  // R2: nothing new is started while the core is still working
  assert_one_inflight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !core_done) |=> !core_start);

  // R6: stopping drops the single active flag on the next edge
  assert_single_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single_stop |=> !single_active);

  // R7: abandoning an in-flight single wipes its result
  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_single |=> (!single_valid && single_result == '0));

  // R8: live work always shows up in an active flag
  assert_active_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !abort_q) |-> (single_active || scan_run));
endmodule

// File: rtl/adc_conv_arbiter.sv
module adc_conv_arbiter
  import adcarb_pkg::*;
#(
  parameter int NTRIG = 8,
  parameter int NCHAN = 8,
  parameter int RES_W = 12,
  localparam int TSEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_start_cmd,
  input  logic              single_stop_cmd,
  input  logic              scan_start_cmd,
  input  logic              scan_stop_cmd,
  input  logic              tailgate_en,
  input  logic              single_hw_en,
  input  logic [TSEL_W-1:0] single_hw_sel,
  input  logic              scan_hw_en,
  input  logic [TSEL_W-1:0] scan_hw_sel,
  input  logic [NTRIG-1:0]  hw_trig,
  input  logic [CH_W-1:0]   single_chan,
  input  logic [NCHAN-1:0]  scan_mask,
  output logic              core_start,
  output logic [CH_W-1:0]   core_chan,
  input  logic              core_done,
  input  logic [RES_W-1:0]  core_result,
  output logic              single_active,
  output logic              scan_active,
  output logic [RES_W-1:0]  single_result,
  output logic              single_valid,
  output logic [RES_W-1:0]  scan_result,
  output logic [CH_W-1:0]   scan_result_chan,
  output logic              scan_valid
);
  localparam int NCLS = 2;

  logic [NCLS-1:0]   cls_start, cls_stop_cmd, cls_hw_en, cls_req, cls_stop;
  logic [TSEL_W-1:0] cls_sel [NCLS];

  assign cls_start[CLS_SINGLE]    = single_start_cmd;
  assign cls_start[CLS_SCAN]      = scan_start_cmd;
  assign cls_stop_cmd[CLS_SINGLE] = single_stop_cmd;
  assign cls_stop_cmd[CLS_SCAN]   = scan_stop_cmd;
  assign cls_hw_en[CLS_SINGLE]    = single_hw_en;
  assign cls_hw_en[CLS_SCAN]      = scan_hw_en;
  assign cls_sel[CLS_SINGLE]      = single_hw_sel;
  assign cls_sel[CLS_SCAN]        = scan_hw_sel;

  for (genvar c = 0; c < NCLS; c++) begin : g_trig
    adcarb_trig_sel #(.NTRIG(NTRIG)) u_trig (
      .sw_start (cls_start[c]),
      .sw_stop  (cls_stop_cmd[c]),
      .hw_en    (cls_hw_en[c]),
      .hw_sel   (cls_sel[c]),
      .hw_trig  (hw_trig),
      .req      (cls_req[c]),
      .stop_eff (cls_stop[c])
    );
  end

  logic            scan_run, scan_has_next, scan_left_empty, scan_issue, scan_end, scan_load;
  logic [CH_W-1:0] scan_next_chan;

  // a scan request while a sequence runs is merged
  assign scan_load = cls_req[CLS_SCAN] && !scan_run;

  adcarb_scan_seq #(.NCHAN(NCHAN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (scan_load),
    .mask       (scan_mask),
    .advance    (scan_issue),
    .finish     (scan_end),
    .kill       (cls_stop[CLS_SCAN]),
    .run        (scan_run),
    .has_next   (scan_has_next),
    .next_chan  (scan_next_chan),
    .left_empty (scan_left_empty)
  );

  adcarb_core_ctl #(.NCHAN(NCHAN), .RES_W(RES_W)) u_ctl (
    .clk              (clk),
    .rst_n            (rst_n),
    .single_req       (cls_req[CLS_SINGLE]),
    .single_stop      (cls_stop[CLS_SINGLE]),
    .single_chan      (single_chan),
    .tailgate_en      (tailgate_en),
    .scan_stop        (cls_stop[CLS_SCAN]),
    .scan_run         (scan_run),
    .scan_has_next    (scan_has_next),
    .scan_next_chan   (scan_next_chan),
    .scan_left_empty  (scan_left_empty),
    .core_done        (core_done),
    .core_result      (core_result),
    .scan_issue       (scan_issue),
    .scan_end         (scan_end),
    .core_start       (core_start),
    .core_chan        (core_chan),
    .single_active    (single_active),
    .single_result    (single_result),
    .single_valid     (single_valid),
    .scan_result      (scan_result),
    .scan_result_chan (scan_result_chan),
    .scan_valid       (scan_valid)
  );

  assign scan_active = scan_run;

  // R6: stopping the scan drops its active flag on the next edge
  assert_scan_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cls_stop[CLS_SCAN] |=> !scan_active);
endmodule

// File: tb/adc_conv_arbiter_test.sv
module adc_conv_arbiter_test;
  localparam int NTRIG = 8;
  localparam int NCHAN = 8;
  localparam int RES_W = 12;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_start_cmd = 0, single_stop_cmd = 0, scan_start_cmd = 0, scan_stop_cmd = 0;
  logic tailgate_en = 0, single_hw_en = 0, scan_hw_en = 0;
  logic [2:0] single_hw_sel = 0, scan_hw_sel = 0;
  logic [NTRIG-1:0] hw_trig = 0;
  logic [2:0] single_chan = 3'd7;
  logic [NCHAN-1:0] scan_mask = 0;
  logic core_start, core_done = 0;
  logic [2:0] core_chan;
  logic [RES_W-1:0] core_result = 0;
  logic single_active, scan_active, single_valid, scan_valid;
  logic [RES_W-1:0] single_result, scan_result;
  logic [2:0] scan_result_chan;

  adc_conv_arbiter #(.NTRIG(NTRIG), .NCHAN(NCHAN), .RES_W(RES_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .single_start_cmd(single_start_cmd), .single_stop_cmd(single_stop_cmd),
    .scan_start_cmd(scan_start_cmd), .scan_stop_cmd(scan_stop_cmd),
    .tailgate_en(tailgate_en),
    .single_hw_en(single_hw_en), .single_hw_sel(single_hw_sel),
    .scan_hw_en(scan_hw_en), .scan_hw_sel(scan_hw_sel),
    .hw_trig(hw_trig), .single_chan(single_chan), .scan_mask(scan_mask),
    .core_start(core_start), .core_chan(core_chan),
    .core_done(core_done), .core_result(core_result),
    .single_active(single_active), .scan_active(scan_active),
    .single_result(single_result), .single_valid(single_valid),
    .scan_result(scan_result), .scan_result_chan(scan_result_chan),
    .scan_valid(scan_valid)
  );

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, starts = 0;
  int done_cyc = 0, gap = 0, mdl_cnt = 0, mdl_seq = 0;
  logic [2:0] mdl_chan = 0;
  logic [RES_W-1:0] last_res = 0;
  int exp_q[$];
  string cur_req = "R1";
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model with fixed latency
  always @(negedge clk) begin
    core_done = 1'b0;
    if (mdl_cnt > 0) begin
      mdl_cnt--;
      if (mdl_cnt == 0) begin
        core_done   = 1'b1;
        core_result = {mdl_chan, 9'(mdl_seq)};
        last_res    = core_result;
        done_cyc    = cyc;
      end
    end
    if (rst_n && core_start) begin
      if (mdl_cnt != 0) chk("R2 overlap", mdl_cnt, 0);
      mdl_cnt  = LAT;
      mdl_chan = core_chan;
      mdl_seq++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && core_start) begin
      starts++;
      gap = cyc - done_cyc;
      if (exp_q.size() == 0) chk({cur_req, " unexpected start chan"}, int'(core_chan), -1);
      else chk({cur_req, " start chan"}, int'(core_chan), exp_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic s_go, input logic s_halt, input logic c_go, input logic c_halt);
    single_start_cmd = s_go; single_stop_cmd = s_halt;
    scan_start_cmd = c_go;   scan_stop_cmd = c_halt;
    @(negedge clk);
    single_start_cmd = 0; single_stop_cmd = 0; scan_start_cmd = 0; scan_stop_cmd = 0;
  endtask

  task automatic trig_pulse(input int idx);
    hw_trig = '0;
    hw_trig[idx] = 1'b1;
    @(negedge clk);
    hw_trig = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    tick(3);
    chk("R1 core_start in reset", core_start, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 single_active", single_active, 0);
    chk("R1 scan_active", scan_active, 0);
    chk("R1 single_valid", single_valid, 0);
    chk("R1 scan_valid", scan_valid, 0);
    chk("R1 single_result", single_result, 0);
    chk("R1 scan_result", scan_result, 0);
    chk("R1 scan_result_chan", scan_result_chan, 0);

    // single software start, issue latency and result
    cur_req = "R2"; exp_q.push_back(7);
    cmd(1, 0, 0, 0);
    chk("R2 no start yet", core_start, 0);
    tick(1);
    chk("R2 start second cycle", core_start, 1);
    chk("R8 single active in flight", single_active, 1);
    tick(8);
    chk("R11 single_valid", single_valid, 1);
    chk("R11 single_result", single_result, last_res);
    chk("R8 single idle", single_active, 0);
    chk("R2 queue", exp_q.size(), 0);

    // scan order
    cur_req = "R4"; scan_mask = 8'b1011_0101;
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(4);
    exp_q.push_back(5); exp_q.push_back(7);
    cmd(0, 0, 1, 0);
    tick(30);
    chk("R4 queue", exp_q.size(), 0);
    chk("R11 scan_valid", scan_valid, 1);
    chk("R11 scan_result_chan", scan_result_chan, 7);
    chk("R11 scan_result", scan_result, last_res);
    chk("R8 scan idle", scan_active, 0);
    scan_mask = 8'h00;
    cmd(0, 0, 1, 0);
    chk("R4 empty mask inactive", scan_active, 0);
    tick(8);

    // priority
    cur_req = "R3"; scan_mask = 8'b0000_0110;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(7);
    cmd(1, 0, 1, 0);
    tick(25);
    chk("R3 queue", exp_q.size(), 0);

    // no preemption of a running single
    cur_req = "R2"; scan_mask = 8'h01;
    exp_q.push_back(7); exp_q.push_back(0);
    cmd(1, 0, 0, 0);
    tick(2);
    cmd(0, 0, 1, 0);
    tick(15);
    chk("R2 no preempt queue", exp_q.size(), 0);

    // tailgate
    cur_req = "R5"; tailgate_en = 1; scan_mask = 8'h09;
    s0 = starts;
    cmd(1, 0, 0, 0);
    tick(20);
    chk("R5 held single", starts - s0, 0);
    chk("R8 held single active", single_active, 1);
    exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(7);
    cmd(0, 0, 1, 0);
    tick(25);
    chk("R5 queue", exp_q.size(), 0);
    chk("R5 gap after scan end", gap, 1);
    tailgate_en = 0;

    // stop of a held single: no conversion in flight
    cur_req = "R6"; tailgate_en = 1;
    cmd(1, 0, 0, 0);
    tick(3);
    cmd(0, 1, 0, 0);
    chk("R6 held single stopped", single_active, 0);
    chk("R7 results kept", single_valid, 1);
    tailgate_en = 0; scan_mask = 8'h01;
    exp_q.push_back(0);
    cmd(0, 0, 1, 0);
    tick(12);
    chk("R6 pending dropped", exp_q.size(), 0);

    // hardware trigger selection
    cur_req = "R9"; single_hw_en = 1; single_hw_sel = 3'd3;
    s0 = starts;
    trig_pulse(2);
    tick(8);
    chk("R9 other line ignored", starts - s0, 0);
    exp_q.push_back(7);
    trig_pulse(3);
    tick(10);
    chk("R9 hw single", exp_q.size(), 0);
    exp_q.push_back(7);
    cmd(1, 0, 0, 0);
    tick(10);
    chk("R9 sw with hw enabled", exp_q.size(), 0);
    scan_hw_en = 1; scan_hw_sel = 3'd5; scan_mask = 8'h10;
    exp_q.push_back(4);
    trig_pulse(5);
    tick(10);
    chk("R9 hw scan", exp_q.size(), 0);
    chk("R9 hw scan chan", scan_result_chan, 4);
    single_hw_en = 0; scan_hw_en = 0;

    // merging
    cur_req = "R10"; s0 = starts;
    exp_q.push_back(7);
    cmd(1, 0, 0, 0); cmd(1, 0, 0, 0); cmd(1, 0, 0, 0);
    tick(10);
    chk("R10 single merged", starts - s0, 1);
    scan_mask = 8'h03;
    exp_q.push_back(0); exp_q.push_back(1);
    cmd(0, 0, 1, 0);
    tick(3);
    cmd(0, 0, 1, 0);
    tick(20);
    chk("R10 scan merged", exp_q.size(), 0);

    // stop during single conversion
    cur_req = "R7"; exp_q.push_back(7);
    cmd(1, 0, 0, 0);
    tick(2);
    cmd(0, 1, 0, 0);
    chk("R6 single stop active", single_active, 0);
    chk("R7 single_valid cleared", single_valid, 0);
    chk("R7 single_result cleared", single_result, 0);
    tick(10);
    chk("R7 late done dropped", single_valid, 0);
    chk("R7 queue", exp_q.size(), 0);

    // start and stop together
    cur_req = "R6"; exp_q.push_back(7);
    cmd(1, 1, 0, 0);
    chk("R6 start wins", single_active, 1);
    tick(10);
    chk("R6 start wins queue", exp_q.size(), 0);
    chk("R6 start wins result", single_valid, 1);

    // scan stop mid conversion
    cur_req = "R7"; scan_mask = 8'hFF;
    exp_q.push_back(0);
    cmd(0, 0, 1, 0);
    tick(2);
    cmd(0, 0, 0, 1);
    chk("R6 scan stop active", scan_active, 0);
    chk("R7 scan_valid cleared", scan_valid, 0);
    tick(20);
    chk("R7 scan late done dropped", scan_valid, 0);
    chk("R7 scan queue", exp_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule